// File: doc/BRIEF.md
# Serial Peripheral Host Interface and Interrupt Logic

This block sits between a byte-wide host bus and the core of an asynchronous serial port. It decodes three chip-select inputs, a register-select line and a read/write line, all qualified by an enable strobe. Reads reach a receive data register and a status register. Writes reach a control register and a transmit data register. The block drives an 8-bit tri-state data bus only while a selected read is in progress. Each enable pulse produces at most one single-cycle strobe toward the serial core, and that strobe is issued after the enable falls. A long enable therefore never repeats a side effect.

The block also keeps the receive holding register and the flags that describe it: full, overrun, framing and parity. It keeps a carrier-loss latch and an empty flag for the transmit register. From these it builds one active-low interrupt request. The transmit and receive causes have separate enables. The clear rules depend on the order of accesses: overrun and carrier-loss interrupts clear only when a status read that saw the flag is followed by a data read. A master-reset code in the control register holds every flag cleared until another code is written.

Top module: `sio_host_if`

## Requirements
- R1: The block is selected only when cs_a=1, cs_b=1 and cs_c_n=0. Any other chip-select combination gives no bus drive and no strobe.
- R2: data_oe is high, and host_data is driven, only while en=1, the block is selected and rd_wr=1. reg_sel=1 returns the receive data register and reg_sel=0 returns the status register.
- R3: A selected write with rd_wr=0 takes effect once per enable pulse, after en falls. reg_sel=0 loads the control register (ctrl_out). reg_sel=1 loads tx_byte and raises tx_wr for exactly one cycle, however long en is held.
- R4: The status bit positions are: 0 receive full, 1 transmit empty, 2 overrun, 3 carrier lost, 4 framing error, 5 parity error, 6 the current cts_n level, 7 interrupt active.
- R5: irq_n is low exactly when an enabled interrupt cause is present, and status bit 7 equals the inverse of irq_n.
- R6: The transmit cause is control bits 6:5 = 01 together with status bit 1. A transmit-data write clears the empty flag and tx_taken sets it again.
- R7: Status bit 1 reads 0 while cts_n=1 or while the master-reset code is in place, even when the transmit register is empty.
- R8: The receive cause is control bit 7 = 1 together with any of receive full, overrun or carrier lost. With bit 7 = 0 these flags raise no interrupt.
- R9: rx_done loads rx_byte, rx_frm_err and rx_par_err and sets receive full. A data-register read clears receive full and the framing and parity flags, and pulses rx_rd once.
- R10: rx_done while receive full is set, with no data read in the same cycle, sets overrun and keeps the unread byte.
- R11: Overrun and carrier lost clear only on a data read that follows a status read made while the flag was set. A data read alone leaves them set.
- R12: A 0-to-1 transition of dcd_n sets carrier lost. A line that stays high does not set it again.
- R13: Reset loads control 0x03 (the master-reset code in bits 1:0) and marks the transmit register empty. While bits 1:0 = 11, all flags stay cleared, and rx_done has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bus enable strobe |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| reg_sel | input | 1 | 1 = data registers, 0 = control/status |
| rd_wr | input | 1 | 1 = read, 0 = write |
| host_data | inout | 8 | Tri-state host data bus |
| data_oe | output | 1 | Bus driver enable |
| irq_n | output | 1 | Interrupt request, active low |
| ctrl_out | output | 8 | Control register contents to the serial core |
| tx_byte | output | 8 | Transmit data register |
| tx_wr | output | 1 | One-cycle transmit-data write strobe |
| tx_taken | input | 1 | Core moved the transmit byte into its shifter |
| rx_byte | input | 8 | Character from the core |
| rx_done | input | 1 | One-cycle pulse: a new character is available |
| rx_frm_err | input | 1 | Framing error of the offered character |
| rx_par_err | input | 1 | Parity error of the offered character |
| rx_rd | output | 1 | One-cycle receive-data read strobe |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |

## Verification
The properties assume that the enable strobe and the bus qualifiers are synchronous to clk. They also assume that each en pulse lasts at least one clock and is followed by at least one low cycle, so that the falling edge is seen. The properties further assume that rx_done and tx_taken are single-cycle pulses. The stimulus keeps to these assumptions: it changes every bus input on the falling clock edge, holds en for one or more whole cycles, and leaves three idle cycles after every access before the next access or core pulse.

// File: rtl/sio_host_pkg.sv
package sio_host_pkg;

    localparam int DW = 8;
    localparam int DIV_W = 2;
    localparam int TXC_W = 2;
    localparam int FMT_W = DW - DIV_W - TXC_W - 1;

    localparam logic [DIV_W-1:0] DIV_MRESET = 2'b11;
    localparam logic [TXC_W-1:0] TXC_IRQ_ON = 2'b01;
    localparam logic [DW-1:0]    CTRL_RST   = {{(DW-DIV_W){1'b0}}, DIV_MRESET};

    // control register: receive irq enable, transmit control, format, divide
    typedef struct packed {
        logic             rx_ie;
        logic [TXC_W-1:0] tx_ctl;
        logic [FMT_W-1:0] fmt;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    // status register, msb first
    typedef struct packed {
        logic irq;
        logic cts_hi;
        logic par_err;
        logic frm_err;
        logic dcd_lost;
        logic ovr;
        logic tde;
        logic rdf;
    } stat_t;

    // one-cycle strobes produced per bus cycle
    typedef struct packed {
        logic wr_ctrl;
        logic wr_tx;
        logic rd_stat;
        logic rd_data;
    } strobe_t;

    function automatic logic is_mreset(ctrl_t c);
        return c.div == DIV_MRESET;
    endfunction

    function automatic logic tx_irq_on(ctrl_t c);
        return c.tx_ctl == TXC_IRQ_ON;
    endfunction

endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
    import sio_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cs_a,
    input  logic          cs_b,
    input  logic          cs_c_n,
    input  logic          reg_sel,
    input  logic          rd_wr,
    input  logic [DW-1:0] wdata,
    output logic          drive_oe,
    output strobe_t       stb,
    output logic [DW-1:0] wbyte
);

    logic          hit;
    logic          en_q;
    logic          fall;
    logic          cap_hit, cap_rs, cap_rw;
    logic [DW-1:0] cap_data;

    assign hit      = cs_a & cs_b & ~cs_c_n;
    assign drive_oe = en & hit & rd_wr;
    assign fall     = en_q & ~en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            cap_hit  <= 1'b0;
            cap_rs   <= 1'b0;
            cap_rw   <= 1'b1;
            cap_data <= '0;
            stb      <= '0;
            wbyte    <= '0;
        end else begin
            en_q <= en;
            if (en) begin
                cap_hit  <= hit;
                cap_rs   <= reg_sel;
                cap_rw   <= rd_wr;
                cap_data <= wdata;
            end
            stb.wr_ctrl <= fall & cap_hit & ~cap_rw & ~cap_rs;
            stb.wr_tx   <= fall & cap_hit & ~cap_rw &  cap_rs;
            stb.rd_stat <= fall & cap_hit &  cap_rw & ~cap_rs;
            stb.rd_data <= fall & cap_hit &  cap_rw &  cap_rs;
            if (fall && cap_hit && !cap_rw)
                wbyte <= cap_data;
        end
    end

endmodule

// File: rtl/sio_tx_flags.sv
module sio_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic mrst,
    input  logic wr_tx,
    input  logic tx_taken,
    input  logic cts_n,
    output logic tde_vis
);

    logic tde;

    always_ff @(posedge clk) begin
        if (rst || mrst)
            tde <= 1'b1;
        else if (wr_tx)
            tde <= 1'b0;
        else if (tx_taken)
            tde <= 1'b1;
    end

    assign tde_vis = tde & ~cts_n & ~mrst;

endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
    import sio_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          frm_in,
    input  logic          par_in,
    input  logic          dcd_n,
    input  logic          rd_stat,
    input  logic          rd_data,
    output logic [DW-1:0] hold,
    output logic          full,
    output logic          ovr,
    output logic          car,
    output logic          frm,
    output logic          par
);

    logic dcd_q;
    logic dcd_rise;
    logic load;
    logic lost;
    logic ovr_arm, car_arm;

    assign dcd_rise = dcd_n & ~dcd_q;
    assign load     = rx_done & (~full | rd_data);
    assign lost     = rx_done & full & ~rd_data;

    always_ff @(posedge clk) begin
        if (rst) dcd_q <= 1'b1;
        else     dcd_q <= dcd_n;
    end

    always_ff @(posedge clk) begin
        if (rst || mrst) begin
            hold    <= '0;
            full    <= 1'b0;
            frm     <= 1'b0;
            par     <= 1'b0;
            ovr     <= 1'b0;
            car     <= 1'b0;
            ovr_arm <= 1'b0;
            car_arm <= 1'b0;
        end else begin
            if (load) begin
                hold <= rx_byte;
                full <= 1'b1;
                frm  <= frm_in;
                par  <= par_in;
            end else if (rd_data) begin
                full <= 1'b0;
                frm  <= 1'b0;
                par  <= 1'b0;
            end

            if (lost) begin
                ovr     <= 1'b1;
                ovr_arm <= 1'b0;
            end else if (rd_data) begin
                if (ovr_arm) ovr <= 1'b0;
                ovr_arm <= 1'b0;
            end else if (rd_stat && ovr) begin
                ovr_arm <= 1'b1;
            end

            if (dcd_rise) begin
                car     <= 1'b1;
                car_arm <= 1'b0;
            end else if (rd_data) begin
                if (car_arm) car <= 1'b0;
                car_arm <= 1'b0;
            end else if (rd_stat && car) begin
                car_arm <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_host_if.sv
module sio_host_if
    import sio_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cs_a,
    input  logic          cs_b,
    input  logic          cs_c_n,
    input  logic          reg_sel,
    input  logic          rd_wr,
    inout  wire  [7:0]    host_data,
    output logic          data_oe,
    output logic          irq_n,
    output logic [7:0]    ctrl_out,
    output logic [7:0]    tx_byte,
    output logic          tx_wr,
    input  logic          tx_taken,
    input  logic [7:0]    rx_byte,
    input  logic          rx_done,
    input  logic          rx_frm_err,
    input  logic          rx_par_err,
    output logic          rx_rd,
    input  logic          cts_n,
    input  logic          dcd_n
);

    strobe_t       stb;
    logic [DW-1:0] wbyte;
    ctrl_t         ctrl_q;
    logic          mrst;
    logic          tde_vis;
    logic [DW-1:0] hold;
    logic          full, ovr, car, frm, par;
    logic          irq_tx, irq_rx, irq;
    stat_t         stat;
    logic [DW-1:0] rdata;

    sio_bus_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cs_a     (cs_a),
        .cs_b     (cs_b),
        .cs_c_n   (cs_c_n),
        .reg_sel  (reg_sel),
        .rd_wr    (rd_wr),
        .wdata    (host_data),
        .drive_oe (data_oe),
        .stb      (stb),
        .wbyte    (wbyte)
    );

    always_ff @(posedge clk) begin
        if (rst)              ctrl_q <= ctrl_t'(CTRL_RST);
        else if (stb.wr_ctrl) ctrl_q <= ctrl_t'(wbyte);
    end

    always_ff @(posedge clk) begin
        if (rst)            tx_byte <= '0;
        else if (stb.wr_tx) tx_byte <= wbyte;
    end

    assign mrst = is_mreset(ctrl_q);

    sio_tx_flags u_tx (
        .clk      (clk),
        .rst      (rst),
        .mrst     (mrst),
        .wr_tx    (stb.wr_tx),
        .tx_taken (tx_taken),
        .cts_n    (cts_n),
        .tde_vis  (tde_vis)
    );

    sio_rx_flags u_rx (
        .clk     (clk),
        .rst     (rst),
        .mrst    (mrst),
        .rx_done (rx_done),
        .rx_byte (rx_byte),
        .frm_in  (rx_frm_err),
        .par_in  (rx_par_err),
        .dcd_n   (dcd_n),
        .rd_stat (stb.rd_stat),
        .rd_data (stb.rd_data),
        .hold    (hold),
        .full    (full),
        .ovr     (ovr),
        .car     (car),
        .frm     (frm),
        .par     (par)
    );

    assign irq_tx = tx_irq_on(ctrl_q) & tde_vis;
    assign irq_rx = ctrl_q.rx_ie & (full | ovr | car);
    assign irq    = irq_tx | irq_rx;

    assign stat = '{irq: irq, cts_hi: cts_n, par_err: par, frm_err: frm,
                    dcd_lost: car, ovr: ovr, tde: tde_vis, rdf: full};

    assign rdata     = reg_sel ? hold : stat;
    assign host_data = data_oe ? rdata : {DW{1'bz}};
    assign irq_n     = ~irq;
    assign ctrl_out  = ctrl_q;
    assign tx_wr     = stb.wr_tx;
    assign rx_rd     = stb.rd_data;

endmodule

// File: rtl/sio_host_chk.sv
module sio_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       cs_a,
    input logic       cs_b,
    input logic       cs_c_n,
    input logic       rd_wr,
    input logic       data_oe,
    input logic       irq_n,
    input logic       tx_wr,
    input logic       rx_rd,
    input logic [7:0] stat,
    input logic [7:0] ctrl
);

    p_oe_needs_sel_r1: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (cs_a && cs_b && !cs_c_n && en && rd_wr));

    p_tx_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !tx_wr);

    p_irq_mirror_r5: assert property (@(posedge clk) disable iff (rst)
        irq_n == !stat[7]);

    p_tx_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl[6:5] == 2'b01 && stat[1]) |-> !irq_n);

    p_rx_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        rx_rd |=> !rx_rd);

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && !rx_rd && ctrl[1:0] != 2'b11) |=> stat[2]);

    p_mreset_clear_r13: assert property (@(posedge clk) disable iff (rst)
        (ctrl[1:0] == 2'b11 && $past(ctrl[1:0]) == 2'b11) |-> (stat[5:0] == 6'b0));

endmodule

bind sio_host_if sio_host_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cs_a    (cs_a),
    .cs_b    (cs_b),
    .cs_c_n  (cs_c_n),
    .rd_wr   (rd_wr),
    .data_oe (data_oe),
    .irq_n   (irq_n),
    .tx_wr   (tx_wr),
    .rx_rd   (rx_rd),
    .stat    (stat),
    .ctrl    (ctrl_q)
);

// File: tb/tb_sio_host_if.sv
module tb_sio_host_if;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {cs_a,cs_b,cs_c_n}[23:21] rs[20] rw[19] wdata[18:11] exp_oe[10] exp_rd[9:2] exp_txw[1:0]
    localparam logic [23:0] VEC [NVEC] = '{
        {3'b110, 1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 2'd0},
        {3'b111, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 2'd0},
        {3'b010, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 2'd0},
        {3'b100, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 2'd0},
        {3'b110, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 2'd0},
        {3'b110, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 2'd0},
        {3'b111, 1'b1, 1'b0, 8'h55, 1'b0, 8'h00, 2'd0},
        {3'b110, 1'b1, 1'b0, 8'hA5, 1'b0, 8'h00, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1;
    logic       reg_sel = 1'b0, rd_wr = 1'b1;
    logic       drv_en = 1'b0;
    logic [7:0] drv_val = 8'h00;
    wire  [7:0] dbus;
    logic       data_oe, irq_n, tx_wr, rx_rd;
    logic [7:0] ctrl_out, tx_byte;
    logic       tx_taken = 1'b0, rx_done = 1'b0, rx_frm_err = 1'b0, rx_par_err = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       cts_n = 1'b0, dcd_n = 1'b0;

    int checks = 0;
    int failures = 0;
    int txw_cnt = 0;
    int rxr_cnt = 0;
    bit done = 1'b0;

    logic       s_oe;
    logic [7:0] s_rd;

    assign dbus = drv_en ? drv_val : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_host_if dut (
        .clk(clk), .rst(rst), .en(en), .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .reg_sel(reg_sel), .rd_wr(rd_wr), .host_data(dbus), .data_oe(data_oe),
        .irq_n(irq_n), .ctrl_out(ctrl_out), .tx_byte(tx_byte), .tx_wr(tx_wr),
        .tx_taken(tx_taken), .rx_byte(rx_byte), .rx_done(rx_done),
        .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_rd(rx_rd),
        .cts_n(cts_n), .dcd_n(dcd_n)
    );

    always @(negedge clk) begin
        if (tx_wr) txw_cnt++;
        if (rx_rd) rxr_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic [2:0] cs, input logic rs, input logic rw,
                       input logic [7:0] wd, input int hold);
        @(negedge clk);
        {cs_a, cs_b, cs_c_n} = cs;
        reg_sel = rs;
        rd_wr   = rw;
        drv_en  = !rw;
        drv_val = wd;
        en      = 1'b1;
        repeat (hold) @(negedge clk);
        s_oe = data_oe;
        s_rd = dbus;
        en     = 1'b0;
        drv_en = 1'b0;
        {cs_a, cs_b, cs_c_n} = 3'b000;
        idle(3);
    endtask

    task automatic rd_status(output logic [7:0] v);
        bus(3'b110, 1'b0, 1'b1, 8'h00, 1);
        v = s_rd;
    endtask

    task automatic rd_data(output logic [7:0] v);
        bus(3'b110, 1'b1, 1'b1, 8'h00, 1);
        v = s_rd;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        bus(3'b110, 1'b0, 1'b0, v, 1);
    endtask

    task automatic wr_tx(input logic [7:0] v);
        bus(3'b110, 1'b1, 1'b0, v, 1);
    endtask

    task automatic rx_char(input logic [7:0] b, input logic fe, input logic pe);
        @(negedge clk);
        rx_byte = b; rx_frm_err = fe; rx_par_err = pe; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; rx_frm_err = 1'b0; rx_par_err = 1'b0;
        idle(2);
    endtask

    task automatic pulse_taken();
        @(negedge clk); tx_taken = 1'b1;
        @(negedge clk); tx_taken = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t0;
        idle(3);
        rst = 1'b0;
        idle(2);

        // reset state
        chk("R5 irq idle after reset", irq_n, 1);
        chk("R13 ctrl reset value", ctrl_out, 8'h03);
        chk("R2 no drive at rest", data_oe, 0);
        rd_status(v);
        chk("R7 tx empty masked in master reset", v, 8'h00);

        // flags held clear under master reset
        rx_char(8'h77, 1'b1, 1'b0);
        rd_status(v);
        chk("R13 rx_done ignored in master reset", v, 8'h00);
        wr_ctrl(8'h00);
        rd_status(v);
        chk("R13 flags after leaving master reset", v, 8'h02);

        // vector walk: decode, read steering, write steering
        for (int i = 0; i < NVEC; i++) begin
            t0 = txw_cnt;
            bus(VEC[i][23:21], VEC[i][20], VEC[i][19], VEC[i][18:11], 1);
            chk($sformatf("R1 R2 vec%0d oe", i), s_oe, VEC[i][10]);
            if (VEC[i][10]) chk($sformatf("R2 vec%0d rdata", i), s_rd, VEC[i][9:2]);
            chk($sformatf("R3 vec%0d tx_wr pulses", i), txw_cnt - t0, VEC[i][1:0]);
        end
        chk("R3 tx_byte holds selected write", tx_byte, 8'hA5);
        rd_status(v);
        chk("R6 write clears tx empty", v, 8'h00);
        pulse_taken();
        rd_status(v);
        chk("R6 tx_taken sets tx empty", v, 8'h02);

        // transmit interrupt and clear-to-send
        wr_ctrl(8'h20);
        chk("R3 ctrl write", ctrl_out, 8'h20);
        chk("R6 tx irq asserted", irq_n, 0);
        rd_status(v);
        chk("R5 status irq bit", v, 8'h82);
        @(negedge clk); cts_n = 1'b1; idle(2);
        chk("R7 cts high removes tx irq", irq_n, 1);
        rd_status(v);
        chk("R7 cts high masks tx empty", v, 8'h40);
        @(negedge clk); cts_n = 1'b0; idle(2);
        chk("R7 cts low restores tx irq", irq_n, 0);
        wr_tx(8'h3C);
        chk("R6 tx data write clears irq", irq_n, 1);
        pulse_taken();
        chk("R6 tx_taken re-raises irq", irq_n, 0);

        // long enable gives one strobe
        t0 = txw_cnt;
        bus(3'b110, 1'b1, 1'b0, 8'h99, 8);
        chk("R3 single strobe for long enable", txw_cnt - t0, 1);
        chk("R3 tx_byte after long enable", tx_byte, 8'h99);
        pulse_taken();

        // receive path
        wr_ctrl(8'h80);
        rx_char(8'h5A, 1'b1, 1'b0);
        chk("R8 rx irq on full", irq_n, 0);
        rd_status(v);
        chk("R4 R9 status with framing error", v, 8'h93);
        t0 = rxr_cnt;
        rd_data(v);
        chk("R9 data read value", v, 8'h5A);
        chk("R9 one rx_rd pulse", rxr_cnt - t0, 1);
        chk("R9 data read clears irq", irq_n, 1);
        rd_status(v);
        chk("R9 flags cleared after read", v, 8'h02);
        rx_char(8'h6B, 1'b0, 1'b1);
        rd_status(v);
        chk("R4 parity error bit", v, 8'hA3);
        rd_data(v);

        // overrun ordering
        rx_char(8'h11, 1'b0, 1'b0);
        rx_char(8'h22, 1'b0, 1'b0);
        rd_data(v);
        chk("R10 unread byte kept", v, 8'h11);
        chk("R11 data read alone keeps overrun irq", irq_n, 0);
        rd_status(v);
        chk("R10 overrun status", v, 8'h86);
        rd_data(v);
        chk("R11 status then data clears overrun", irq_n, 1);
        rd_status(v);
        chk("R11 overrun bit cleared", v, 8'h02);

        // carrier loss ordering
        @(negedge clk); dcd_n = 1'b1; idle(2);
        chk("R12 carrier rise raises irq", irq_n, 0);
        rd_data(v);
        chk("R11 data read alone keeps carrier irq", irq_n, 0);
        rd_status(v);
        chk("R12 carrier lost status", v, 8'h8A);
        rd_data(v);
        chk("R11 status then data clears carrier", irq_n, 1);
        idle(3);
        rd_status(v);
        chk("R12 steady high line not re-latched", v, 8'h02);
        @(negedge clk); dcd_n = 1'b0;

        // receive enable off, then master reset clears
        wr_ctrl(8'h00);
        rx_char(8'h44, 1'b0, 1'b0);
        chk("R8 no irq with rx enable off", irq_n, 1);
        rd_status(v);
        chk("R8 full flag without irq", v, 8'h03);
        wr_ctrl(8'h03);
        rd_status(v);
        chk("R13 master reset clears flags", v, 8'h00);
        wr_ctrl(8'h00);
        rd_status(v);
        chk("R13 flags remain clear after exit", v, 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule